// File: doc/BRIEF.md
# Slack-Interval Switching Time Learner

This block judges path timing inside the slack interval of a two-vector delay test. After the second vector is launched, the outputs under observation are sampled by a run of fast observation strobes. The strobes all fall before the normal capture edge. For every output the block finds the strobe at which that output settled. In learn mode, it writes that settle index into a small on-chip table, with one entry per output and per pattern. The values come from a known-good reference die. In test mode, it measures a device under test the same way. It compares each output against the learned index, allowing a programmable tolerance.

Outputs that can glitch would record a false transition time, so a per-output hazard-free mask keeps them out of both learning and judging. A device fails when any judged output settles later than its learned index plus the tolerance, or when it never settles within the strobe run. The result is a pass flag and the lowest failing output index. Both appear one cycle after the capture sample is presented.

A measurement follows a fixed sequence. `start` clears the tracking. One `strobe_valid` cycle is given per strobe, with ascending `strobe_idx`. A final `cap_valid` cycle then presents the value captured at the normal capture time, and the pattern is evaluated in that cycle.

Top module: `settle_timing_learner`

## Requirements
- R1: After reset, `done` is 0, `pass` is 1, `fail_idx` is 0, and every table entry is invalid, so a test-mode pattern judged before any learning passes whatever its timing.
- R2: The settle index of an output is the `strobe_idx` of the first strobe from which every sample up to and including the last strobe equals the value presented with `cap_valid`. A glitch that returns to the final value restarts the run.
- R3: In learn mode, a capture stores each output's settle index at table slot (`pat_idx`, output). Entries of different patterns are independent.
- R4: In test mode, a judged output fails when its measured settle index is greater than the learned index plus `tol`. Both sides are compared without wrap-around.
- R5: A measured index exactly equal to learned plus `tol` passes. One strobe later fails.
- R6: An output whose `hz_free` bit is 0 is never judged in test mode. In learn mode, its entry is stored invalid, so it is also skipped in later tests of that pattern.
- R7: In test mode, a judged output with a valid entry that never settles fails. Never settling means that no sample run ends equal to the capture value, or that no strobe was seen.
- R8: In learn mode, an output that never settles stores an invalid entry, and test mode skips that entry.
- R9: When several outputs fail, `fail_idx` reports the lowest failing index. While `pass` is 1, `fail_idx` is 0.
- R10: `done` is a one-cycle pulse in the cycle after each `cap_valid`. A learn-mode capture always reports `pass`=1. `pass` and `fail_idx` hold their values between pulses.
- R11: An output that settles earlier than its learned index always passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_learn | input | 1 | 1: store settle indices, 0: judge against the table |
| pat_idx | input | $clog2(NPAT) | Pattern number, which selects the table row |
| start | input | 1 | Clears per-output tracking for a new pattern |
| strobe_valid | input | 1 | An observation strobe sample is present |
| strobe_idx | input | $clog2(NSTROBE) | Position of this strobe in the slack interval |
| obs | input | NOUT | Sampled output bits (strobe sample or capture value) |
| cap_valid | input | 1 | `obs` holds the final capture value; evaluate the pattern |
| hz_free | input | NOUT | 1 marks an output known to be free of hazards |
| tol | input | $clog2(NSTROBE) | Allowed lateness in strobe steps |
| done | output | 1 | Result pulse, one cycle after `cap_valid` |
| pass | output | 1 | 1 when no judged output was late or unsettled |
| fail_idx | output | $clog2(NOUT) | Lowest failing output index |

## Verification
The bench builds the block with four outputs, four patterns and eight strobes. With this size it can reach the last strobe, a run that never settles, and every table row within a few dozen cycles. Four outputs allow up to two failures at once and a masked output side by side in one pattern, which exercises the lowest-index choice. Eight strobes leave room for a glitch that leaves the final value and returns, and for checks one step on either side of the tolerance limit.

// File: rtl/settle_timing_learner.sv
module settle_timing_learner #(
  parameter int NOUT    = 8,
  parameter int NPAT    = 16,
  parameter int NSTROBE = 8,
  localparam int OW = $clog2(NOUT),
  localparam int PW = $clog2(NPAT),
  localparam int SW = $clog2(NSTROBE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_learn,
  input  logic [PW-1:0] pat_idx,
  input  logic          start,
  input  logic          strobe_valid,
  input  logic [SW-1:0] strobe_idx,
  input  logic [NOUT-1:0] obs,
  input  logic          cap_valid,
  input  logic [NOUT-1:0] hz_free,
  input  logic [SW-1:0] tol,
  output logic          done,
  output logic          pass,
  output logic [OW-1:0] fail_idx
);

  logic [NOUT-1:0] bad;
  logic [OW-1:0]   first_bad;

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic          seen;
    logic          run_val;
    logic [SW-1:0] run_start;
    logic [SW:0]   tbl [NPAT];
    logic          settled;
    logic [SW:0]   learned;
    logic [SW:0]   limit;

    assign settled = seen && (run_val == obs[g]);
    assign learned = tbl[pat_idx];
    assign limit   = {1'b0, learned[SW-1:0]} + {1'b0, tol};
    assign bad[g]  = hz_free[g] && learned[SW] &&
                     (!settled || ({1'b0, run_start} > limit));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen      <= 1'b0;
        run_val   <= 1'b0;
        run_start <= '0;
        for (int p = 0; p < NPAT; p++) tbl[p] <= '0;
      end else begin
        if (start) begin
          seen <= 1'b0;
        end else if (strobe_valid) begin
          seen <= 1'b1;
          if (!seen || obs[g] != run_val) begin
            run_val   <= obs[g];
            run_start <= strobe_idx;
          end
        end
        if (cap_valid && mode_learn)
          tbl[pat_idx] <= {settled && hz_free[g], run_start};
      end
    end
  end

  always_comb begin
    first_bad = '0;
    for (int o = NOUT - 1; o >= 0; o--)
      if (bad[o]) first_bad = OW'(o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      pass     <= 1'b1;
      fail_idx <= '0;
    end else begin
      done <= cap_valid;
      if (cap_valid) begin
        pass     <= mode_learn || !(|bad);
        fail_idx <= mode_learn ? '0 : first_bad;
      end
    end
  end

endmodule

module settle_timing_learner_chk #(
  parameter int NOUT = 8,
  localparam int OW = $clog2(NOUT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            mode_learn,
  input logic            cap_valid,
  input logic [NOUT-1:0] hz_free,
  input logic            done,
  input logic            pass,
  input logic [OW-1:0]   fail_idx
);

  logic [NOUT-1:0] hz_d;
  logic            learn_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_d    <= '0;
      learn_d <= 1'b0;
    end else begin
      hz_d    <= hz_free;
      learn_d <= mode_learn;
    end
  end

  p_done_follows_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> done);
  p_done_only_after_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |=> !done);
  p_learn_passes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && learn_d) |-> pass);
  p_result_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pass) && $stable(fail_idx)));
  p_masked_never_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pass) |-> hz_d[fail_idx]);
  p_pass_idx_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (fail_idx == '0));

endmodule

bind settle_timing_learner settle_timing_learner_chk #(.NOUT(NOUT)) u_chk (.*);

// File: tb/settle_timing_learner_tb.sv
module settle_timing_learner_tb;
  localparam int NOUT = 4, NPAT = 4, NSTROBE = 8;
  localparam int NEVER = 8, GLITCH = 9;

  logic clk = 0, rst_n = 0;
  logic mode_learn = 0, start = 0, strobe_valid = 0, cap_valid = 0;
  logic [1:0] pat_idx = 0;
  logic [2:0] strobe_idx = 0, tol = 0;
  logic [3:0] obs = 0, hz_free = 4'hF;
  logic done, pass;
  logic [1:0] fail_idx;

  int checks = 0, fails = 0;
  logic r_done, r_pass;
  logic [1:0] r_idx;

  always #4 clk = ~clk;

  settle_timing_learner #(.NOUT(NOUT), .NPAT(NPAT), .NSTROBE(NSTROBE)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_learn(mode_learn), .pat_idx(pat_idx),
    .start(start), .strobe_valid(strobe_valid), .strobe_idx(strobe_idx),
    .obs(obs), .cap_valid(cap_valid), .hz_free(hz_free), .tol(tol),
    .done(done), .pass(pass), .fail_idx(fail_idx));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic wave(input int s, input int k);
    logic [7:0] gl = 8'b1110_0110;
    if (s == GLITCH) return gl[k];
    if (s >= NEVER) return logic'(k % 2);
    return logic'(k >= s);
  endfunction

  function automatic logic capv(input int s);
    return !(s == NEVER);
  endfunction

  task automatic run(input bit learn, input int pat, input int s0, input int s1,
                     input int s2, input int s3, input logic [3:0] hz, input int t);
    int st[4];
    st[0] = s0; st[1] = s1; st[2] = s2; st[3] = s3;
    @(negedge clk);
    mode_learn = learn; pat_idx = 2'(pat); hz_free = hz; tol = 3'(t); start = 1;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < NSTROBE; k++) begin
      strobe_valid = 1; strobe_idx = 3'(k);
      for (int o = 0; o < NOUT; o++) obs[o] = wave(st[o], k);
      @(negedge clk);
    end
    strobe_valid = 0; cap_valid = 1;
    for (int o = 0; o < NOUT; o++) obs[o] = capv(st[o]);
    @(negedge clk);
    cap_valid = 0;
    r_done = done; r_pass = pass; r_idx = fail_idx;
  endtask

  task automatic expect_result(input string req, input bit p, input int idx);
    check(r_done == 1'b1, {req, " done"}, r_done, 1);
    check(r_pass == p, {req, " pass"}, r_pass, p);
    if (!p) check(r_idx == 2'(idx), {req, " fail_idx"}, r_idx, idx);
  endtask

  task automatic t_reset;
    #1;
    check(done == 0, "R1 done at reset", done, 0);
    check(pass == 1, "R1 pass at reset", pass, 1);
    check(fail_idx == 0, "R1 fail_idx at reset", fail_idx, 0);
    run(0, 0, NEVER, NEVER, NEVER, NEVER, 4'hF, 0);
    expect_result("R1 empty table skipped", 1, 0);
  endtask

  task automatic t_learn_and_match;
    run(1, 0, 2, 3, 4, 1, 4'hF, 0);
    expect_result("R10 learn reports pass", 1, 0);
    @(negedge clk);
    check(done == 0, "R10 done is one pulse", done, 0);
    check(pass == 1, "R10 pass held", pass, 1);
    run(0, 0, 2, 3, 4, 1, 4'hF, 0);
    expect_result("R3 same timing passes", 1, 0);
  endtask

  task automatic t_late;
    run(0, 0, 2, 3, 5, 1, 4'hF, 0);
    expect_result("R4 late output 2 fails", 0, 2);
    @(negedge clk);
    check(pass == 0 && fail_idx == 2, "R10 fail result held", fail_idx, 2);
  endtask

  task automatic t_tolerance;
    run(0, 0, 2, 3, 5, 1, 4'hF, 1);
    expect_result("R5 at learned plus tol passes", 1, 0);
    run(0, 0, 2, 3, 6, 1, 4'hF, 1);
    expect_result("R5 one past tol fails", 0, 2);
  endtask

  task automatic t_early;
    run(0, 0, 0, 0, 0, 0, 4'hF, 0);
    expect_result("R11 early settling passes", 1, 0);
  endtask

  task automatic t_mask;
    run(0, 0, 2, 3, 7, 1, 4'b1011, 0);
    expect_result("R6 masked late output ignored", 1, 0);
    run(1, 3, 0, 0, 0, 0, 4'b1110, 0);
    expect_result("R6 learn with mask", 1, 0);
    run(0, 3, 7, 0, 0, 0, 4'hF, 0);
    expect_result("R6 masked learn entry skipped", 1, 0);
  endtask

  task automatic t_lowest;
    run(0, 0, 2, 5, 4, 3, 4'hF, 0);
    expect_result("R9 lowest of outputs 1 and 3", 0, 1);
  endtask

  task automatic t_never_test;
    run(0, 0, NEVER, 3, 4, 1, 4'hF, 0);
    expect_result("R7 unsettled output fails", 0, 0);
  endtask

  task automatic t_never_learn;
    run(1, 1, 1, 1, 1, NEVER, 4'hF, 0);
    expect_result("R8 learn with unsettled output", 1, 0);
    run(0, 1, 1, 1, 1, 7, 4'hF, 0);
    expect_result("R8 invalid entry skipped", 1, 0);
    run(0, 1, 2, 1, 1, 1, 4'hF, 0);
    expect_result("R3 pattern 1 entry independent", 0, 0);
    run(0, 0, 2, 3, 4, 1, 4'hF, 0);
    expect_result("R3 pattern 0 entry kept", 1, 0);
  endtask

  task automatic t_glitch;
    run(1, 2, GLITCH, 0, 0, 0, 4'hF, 0);
    expect_result("R2 learn glitching output", 1, 0);
    run(0, 2, 5, 0, 0, 0, 4'hF, 0);
    expect_result("R2 settle after glitch is 5", 1, 0);
    run(0, 2, 6, 0, 0, 0, 4'hF, 0);
    expect_result("R2 settle 6 beyond learned 5", 0, 0);
  endtask

  initial begin
    #100000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_learn_and_match;
    t_late;
    t_tolerance;
    t_early;
    t_mask;
    t_lowest;
    t_never_test;
    t_never_learn;
    t_glitch;
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule